// File: doc/BRIEF.md
# Misaligned Access Splitting Bus Unit

This unit sits between a processor load/store port and a 16-bit memory bus. It takes one request at a time, of byte, word (2 bytes) or longword (4 bytes) size, at any byte address. It cuts the request into the shortest run of naturally aligned bus cycles: a word cycle only at an even address, and a byte cycle wherever the next byte is odd-addressed or is the last one left. It runs those cycles one after another. Each cycle has its own address phase and completes on its own acknowledge.

Memory is big-endian: the most significant byte of a word or longword lives at the lowest address. On writes each bus cycle carries its slice of the request data. On reads the returned slices are merged into a result register, and completion is signalled only after the last slice has arrived.

Some access classes must always sit at even addresses: instruction fetch, stack, branch table, block transfer and multiply-accumulate operands. A request of such a class at an odd address is refused with a one-cycle alignment fault and produces no bus traffic. Byte-size stack requests and the reserved size code are refused in the same way.

Top module: `misalign_split_unit`

## Requirements
- R1: A byte request (size code 00) issues exactly one byte cycle at its address; the strobe is 10 (lane on bits 15:8) for an even address and 01 (lane on bits 7:0) for an odd address.
- R2: A word request (size code 01) at an even address issues one word cycle with strobe 11. At an odd address it issues two byte cycles, first at A with strobe 01 and then at A+1 with strobe 10.
- R3: A longword request (size code 10) at an address that is a multiple of 2 issues two word cycles, first at A and then at A+2, each with strobe 11.
- R4: A longword request at an odd address issues three cycles in this order: a byte at A (strobe 01), a word at A+1 (strobe 11), and a byte at A+3 (strobe 10). Each cycle's address follows on directly from the bytes of the cycle before it.
- R5: Every bus cycle has a non-zero strobe. Strobe 11 appears only at even addresses, 10 only at even addresses and 01 only at odd addresses.
- R6: While a bus cycle waits for its acknowledge, its address, strobe, write flag and write data stay unchanged.
- R7: On writes, memory ends up holding the request data big-endian: byte A receives the most significant of the request's bytes, and the bytes follow in descending significance at ascending addresses.
- R8: On reads, the result holds the bytes at A upward, with A as the most significant, right-aligned in the 32-bit result. Bits above the request size read as zero.
- R9: The done output is a single-cycle pulse. It rises in the cycle after the final bus cycle is acknowledged, never earlier, and the read result is valid in that same cycle.
- R10: Ready is low from the cycle after an accepted, non-faulting request until done. No bus cycle is ever presented while ready is high.
- R11: A request with class code 1 (fetch), 2 (stack), 3 (branch table), 4 (block transfer) or 5 (multiply-accumulate) at an odd address raises the alignment fault for one cycle and issues no bus cycle. Class codes 0, 6 and 7 are unrestricted.
- R12: A stack-class request (class code 2) of byte size, or any request with size code 11, raises the alignment fault and issues no bus cycle.
- R13: A synchronous active-high reset, even in the middle of a split sequence, returns the unit to idle: ready high, no bus cycle, done and fault low, result zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 word, 10 longword, 11 reserved |
| req_class | input | 3 | Access class code (see R11) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, right-aligned |
| align_fault | output | 1 | One-cycle refusal pulse |
| bus_valid | output | 1 | Bus cycle presented |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | ADDR_W | Byte address of the bus cycle |
| bus_strb | output | 2 | Lane strobes: bit 1 = bits 15:8, bit 0 = bits 7:0 |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_ack | input | 1 | Bus cycle completes at an edge where valid and ack are both high |

## Verification
The assertions watch several properties on every cycle. They check the legality of each strobe against the address parity, the stability of a cycle held by wait states, and that each new piece starts right where the previous one ended. They also check that no bus cycle overlaps a ready state, that done follows an acknowledge and lasts one cycle, and that a fault never coincides with bus traffic. The actual orderings of the pieces for each size and alignment, the big-endian placement of written and read bytes, the fault decoding per class, and recovery from a reset in mid-sequence are shown only by the bench scenarios. Those scenarios compare the recorded bus cycles and a shadow memory against values computed from the requirements.

// File: rtl/msu_pkg.sv
package msu_pkg;

    localparam int REQ_BYTES = 4;
    localparam int BUS_BYTES = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        CL_DATA  = 3'd0,
        CL_FETCH = 3'd1,
        CL_STACK = 3'd2,
        CL_TABLE = 3'd3,
        CL_BLOCK = 3'd4,
        CL_MAC   = 3'd5,
        CL_AUX6  = 3'd6,
        CL_AUX7  = 3'd7
    } class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // byte count of a request or of what remains of it (0..4)
    typedef logic [2:0] bcount_t;

    // one bus cycle of a split request
    typedef struct packed {
        logic       is_word;  // two-byte cycle on both lanes
        logic       lane_hi;  // first byte travels on bits 15:8
        logic [1:0] idx;      // memory-order index of the first byte
    } piece_t;

    function automatic bcount_t size_bytes(input size_e sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic class_needs_even(input class_e cl);
        case (cl)
            CL_FETCH, CL_STACK, CL_TABLE, CL_BLOCK, CL_MAC: return 1'b1;
            default:                                        return 1'b0;
        endcase
    endfunction

    // greedy choice: a word only when aligned and two bytes remain
    function automatic piece_t plan_piece(input logic odd, input bcount_t rem,
                                          input logic [2:0] off);
        piece_t p;
        p.is_word = !odd && (rem >= 3'd2);
        p.lane_hi = !odd;
        p.idx     = off[1:0];
        return p;
    endfunction

    function automatic bcount_t piece_len(input piece_t p);
        return p.is_word ? 3'd2 : 3'd1;
    endfunction

    // memory-order byte k of an n-byte right-aligned big-endian value
    function automatic logic [7:0] pick_byte(input logic [31:0] d, input bcount_t n,
                                             input logic [1:0] k);
        int sh;
        sh = (int'(n) - 1 - int'(k)) * 8;
        if (sh < 0) sh = 0;
        return 8'(d >> sh);
    endfunction

endpackage

// File: rtl/msu_fault_check.sv
module msu_fault_check
    import msu_pkg::*;
(
    input  logic [1:0] size_i,
    input  logic [2:0] class_i,
    input  logic       addr_odd_i,
    output logic       fault_o
);
    size_e  sz;
    class_e cl;
    logic   odd_restricted;
    logic   stack_byte;
    logic   bad_size;

    always_comb begin
        sz             = size_e'(size_i);
        cl             = class_e'(class_i);
        odd_restricted = class_needs_even(cl) && addr_odd_i;
        stack_byte     = (cl == CL_STACK) && (sz == SZ_BYTE);
        bad_size       = (sz == SZ_RSVD);
        fault_o        = odd_restricted || stack_byte || bad_size;
    end
endmodule

// File: rtl/msu_sequencer.sv
module msu_sequencer
    import msu_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [1:0]        req_size_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [31:0]       req_wdata_i,
    input  logic              fault_i,
    input  logic              bus_ack_i,
    output logic              idle_o,
    output logic              accept_o,
    output logic              busy_o,
    output logic              capture_o,
    output logic              write_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output piece_t            piece_o,
    output bcount_t           nbytes_o,
    output logic [31:0]       wdata_o,
    output logic              done_o,
    output logic              fault_o
);
    seq_state_e        st_q;
    logic [ADDR_W-1:0] base_q;
    logic [2:0]        off_q;
    bcount_t           rem_q;
    bcount_t           n_q;
    logic              write_q;
    logic [31:0]       wdata_q;
    logic              done_q;
    logic              fault_q;

    piece_t  cur_piece;
    bcount_t cur_len;
    logic    take;

    always_comb begin
        cur_addr_o = base_q + ADDR_W'(off_q);
        cur_piece  = plan_piece(cur_addr_o[0], rem_q, off_q);
        cur_len    = piece_len(cur_piece);
        take       = (st_q == ST_IDLE) && req_valid_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            base_q  <= '0;
            off_q   <= '0;
            rem_q   <= '0;
            n_q     <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (take) begin
                        if (fault_i) begin
                            fault_q <= 1'b1;
                        end else begin
                            st_q    <= ST_RUN;
                            base_q  <= req_addr_i;
                            off_q   <= '0;
                            rem_q   <= size_bytes(size_e'(req_size_i));
                            n_q     <= size_bytes(size_e'(req_size_i));
                            write_q <= req_write_i;
                            wdata_q <= req_wdata_i;
                        end
                    end
                end
                default: begin
                    if (bus_ack_i) begin
                        off_q <= off_q + cur_len;
                        rem_q <= rem_q - cur_len;
                        if (rem_q == cur_len) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign idle_o    = (st_q == ST_IDLE);
    assign accept_o  = take && !fault_i;
    assign busy_o    = (st_q == ST_RUN);
    assign capture_o = busy_o && bus_ack_i && !write_q;
    assign write_o   = write_q;
    assign piece_o   = cur_piece;
    assign nbytes_o  = n_q;
    assign wdata_o   = wdata_q;
    assign done_o    = done_q;
    assign fault_o   = fault_q;
endmodule

// File: rtl/msu_lane_steer.sv
module msu_lane_steer
    import msu_pkg::*;
(
    input  piece_t      piece_i,
    input  bcount_t     nbytes_i,
    input  logic [31:0] wdata_i,
    output logic [1:0]  strb_o,
    output logic [15:0] lanes_o
);
    logic [7:0] first_b;
    logic [7:0] second_b;

    always_comb begin
        first_b  = pick_byte(wdata_i, nbytes_i, piece_i.idx);
        second_b = pick_byte(wdata_i, nbytes_i, piece_i.idx + 2'd1);
        if (piece_i.is_word) begin
            strb_o  = 2'b11;
            lanes_o = {first_b, second_b};
        end else if (piece_i.lane_hi) begin
            strb_o  = 2'b10;
            lanes_o = {first_b, 8'h00};
        end else begin
            strb_o  = 2'b01;
            lanes_o = {8'h00, first_b};
        end
    end
endmodule

// File: rtl/msu_read_merge.sv
module msu_read_merge
    import msu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear_i,
    input  logic        capture_i,
    input  piece_t      piece_i,
    input  bcount_t     nbytes_i,
    input  logic [15:0] lanes_i,
    output logic [31:0] result_o
);
    for (genvar j = 0; j < REQ_BYTES; j++) begin : g_byte
        logic [7:0] byte_q;
        logic [2:0] pos;
        logic       in_range;
        logic       hit_first;
        logic       hit_second;
        logic [7:0] first_lane;

        always_comb begin
            pos        = nbytes_i - 3'd1 - 3'(j);
            in_range   = 3'(j) < nbytes_i;
            hit_first  = in_range && (pos == {1'b0, piece_i.idx});
            hit_second = in_range && piece_i.is_word &&
                         (pos == ({1'b0, piece_i.idx} + 3'd1));
            first_lane = piece_i.lane_hi ? lanes_i[15:8] : lanes_i[7:0];
        end

        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                byte_q <= 8'h00;
            end else if (capture_i) begin
                if (hit_first)
                    byte_q <= first_lane;
                else if (hit_second)
                    byte_q <= lanes_i[7:0];
            end
        end

        assign result_o[8*j +: 8] = byte_q;
    end
endmodule

// File: rtl/misalign_split_unit.sv
module misalign_split_unit
    import msu_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [2:0]        req_class,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_done,
    output logic [31:0]       rsp_rdata,
    output logic              align_fault,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_strb,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_ack
);
    logic        fault_now;
    logic        idle;
    logic        accept;
    logic        busy;
    logic        capture;
    logic        wr;
    piece_t      piece;
    bcount_t     nbytes;
    logic [31:0] wdata_held;

    msu_fault_check u_fault (
        .size_i     (req_size),
        .class_i    (req_class),
        .addr_odd_i (req_addr[0]),
        .fault_o    (fault_now)
    );

    msu_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_size_i  (req_size),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .fault_i     (fault_now),
        .bus_ack_i   (bus_ack),
        .idle_o      (idle),
        .accept_o    (accept),
        .busy_o      (busy),
        .capture_o   (capture),
        .write_o     (wr),
        .cur_addr_o  (bus_addr),
        .piece_o     (piece),
        .nbytes_o    (nbytes),
        .wdata_o     (wdata_held),
        .done_o      (rsp_done),
        .fault_o     (align_fault)
    );

    msu_lane_steer u_steer (
        .piece_i  (piece),
        .nbytes_i (nbytes),
        .wdata_i  (wdata_held),
        .strb_o   (bus_strb),
        .lanes_o  (bus_wdata)
    );

    msu_read_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (accept),
        .capture_i (capture),
        .piece_i   (piece),
        .nbytes_i  (nbytes),
        .lanes_i   (bus_rdata),
        .result_o  (rsp_rdata)
    );

    assign req_ready = idle;
    assign bus_valid = busy;
    assign bus_write = wr;
endmodule

// File: rtl/msu_checker.sv
module msu_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              align_fault,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_strb,
    input logic [15:0]       bus_wdata,
    input logic              bus_ack
);
    a_r5_strobe_nonzero: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> bus_strb != 2'b00);

    a_r5_strobe_parity: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> ((bus_strb == 2'b01) == bus_addr[0]));

    a_r6_hold_while_waiting: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_strb)
                                  && $stable(bus_write) && $stable(bus_wdata));

    a_r4_next_piece_contiguous: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_ack |=> !bus_valid ||
            (bus_addr == $past(bus_addr) + (($past(bus_strb) == 2'b11) ? ADDR_W'(2) : ADDR_W'(1))));

    a_r9_done_after_ack: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(bus_valid && bus_ack));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r10_no_cycle_when_ready: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> !req_ready);

    a_r11_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> !bus_valid && req_ready && !rsp_done);
endmodule

bind misalign_split_unit msu_checker #(.ADDR_W(ADDR_W)) u_msu_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .align_fault (align_fault),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_strb    (bus_strb),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack)
);

// File: tb/misalign_split_unit_tb_top.sv
`timescale 1ns/1ps
module misalign_split_unit_tb_top;
    localparam int AW = 24;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [2:0]  cls;
        logic [7:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 3'd0, 8'h10, 32'h11223344},
        '{1'b1, 2'd2, 3'd0, 8'h15, 32'hAABBCCDD},
        '{1'b1, 2'd2, 3'd6, 8'h1A, 32'h55667788},
        '{1'b1, 2'd1, 3'd0, 8'h21, 32'h00009A0B},
        '{1'b1, 2'd1, 3'd2, 8'h24, 32'h0000CDEF},
        '{1'b1, 2'd0, 3'd0, 8'h27, 32'h0000005E},
        '{1'b1, 2'd0, 3'd1, 8'h28, 32'h000000A1},
        '{1'b0, 2'd2, 3'd0, 8'h10, 32'h0},
        '{1'b0, 2'd2, 3'd0, 8'h15, 32'h0},
        '{1'b0, 2'd2, 3'd0, 8'h1A, 32'h0},
        '{1'b0, 2'd1, 3'd0, 8'h21, 32'h0},
        '{1'b0, 2'd0, 3'd0, 8'h27, 32'h0},
        '{1'b0, 2'd2, 3'd7, 8'h13, 32'h0},
        '{1'b0, 2'd0, 3'd0, 8'h11, 32'h0},
        '{1'b0, 2'd1, 3'd1, 8'h31, 32'h0},
        '{1'b1, 2'd0, 3'd2, 8'h30, 32'h000000FF},
        '{1'b0, 2'd1, 3'd2, 8'h30, 32'h0},
        '{1'b1, 2'd2, 3'd5, 8'h33, 32'hDEADBEEF},
        '{1'b1, 2'd3, 3'd0, 8'h20, 32'h12345678},
        '{1'b0, 2'd2, 3'd3, 8'h2B, 32'h0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [2:0]    req_class = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_done;
    logic [31:0]   rsp_rdata;
    logic          align_fault;
    logic          bus_valid;
    logic          bus_write;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_strb;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata;
    logic          bus_ack;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] mem     [64];
    logic [7:0] ref_mem [64];
    logic [7:0] log_addr [8];
    logic [1:0] log_strb [8];
    int         log_n;
    int         wait_extra = 0;
    int         wcnt;

    always #2 clk = ~clk;

    misalign_split_unit #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_class(req_class), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .align_fault(align_fault), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // memory bus model: big-endian lanes, configurable wait states
    always_comb bus_rdata = {mem[{bus_addr[5:1], 1'b0}], mem[{bus_addr[5:1], 1'b1}]};

    always @(posedge clk) begin
        if (rst) begin
            bus_ack <= 1'b0;
            wcnt    <= 0;
        end else if (bus_valid && bus_ack) begin
            if (log_n < 8) begin
                log_addr[log_n] <= bus_addr[7:0];
                log_strb[log_n] <= bus_strb;
            end
            log_n <= log_n + 1;
            if (bus_write && bus_strb[1]) mem[{bus_addr[5:1], 1'b0}] <= bus_wdata[15:8];
            if (bus_write && bus_strb[0]) mem[{bus_addr[5:1], 1'b1}] <= bus_wdata[7:0];
            bus_ack <= 1'b0;
            wcnt    <= 0;
        end else if (bus_valid) begin
            if (wcnt >= wait_extra) bus_ack <= 1'b1;
            else                    wcnt    <= wcnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic bit exp_fault(input vec_t v);
        return (v.sz == 2'd3) || (v.cls == 3'd2 && v.sz == 2'd0) ||
               (v.cls >= 3'd1 && v.cls <= 3'd5 && v.addr[0]);
    endfunction

    task automatic run_vec(input vec_t v);
        int         n;
        int         en;
        logic [7:0] ea [3];
        logic [1:0] es [3];
        bit         f;
        bit         rdy_after;
        bit         seen_done;
        bit         seen_fault;
        int         pieces_at_done;
        int         t;
        string      tg;
        logic [31:0] expv;
        logic [31:0] gotv;

        n = nbytes(v.sz);
        f = exp_fault(v);
        en = 0;
        tg = "R1";
        if (v.sz == 2'd0) begin
            tg = "R1"; en = 1; ea[0] = v.addr; es[0] = v.addr[0] ? 2'b01 : 2'b10;
        end else if (v.sz == 2'd1 && !v.addr[0]) begin
            tg = "R2"; en = 1; ea[0] = v.addr; es[0] = 2'b11;
        end else if (v.sz == 2'd1) begin
            tg = "R2"; en = 2; ea[0] = v.addr; es[0] = 2'b01; ea[1] = v.addr + 8'd1; es[1] = 2'b10;
        end else if (!v.addr[0]) begin
            tg = "R3"; en = 2; ea[0] = v.addr; es[0] = 2'b11; ea[1] = v.addr + 8'd2; es[1] = 2'b11;
        end else begin
            tg = "R4"; en = 3; ea[0] = v.addr; es[0] = 2'b01;
            ea[1] = v.addr + 8'd1; es[1] = 2'b11; ea[2] = v.addr + 8'd3; es[2] = 2'b10;
        end
        if (f) begin
            tg = (v.sz == 2'd3 || (v.cls == 3'd2 && v.sz == 2'd0)) ? "R12" : "R11";
            en = 0;
        end

        @(negedge clk);
        log_n     = 0;
        req_write = v.wr;
        req_size  = v.sz;
        req_class = v.cls;
        req_addr  = AW'(v.addr);
        req_wdata = v.data;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rdy_after = req_ready;
        t = 0;
        while (!(rsp_done || align_fault) && t < 200) begin
            @(negedge clk);
            t++;
        end
        seen_done      = rsp_done;
        seen_fault     = align_fault;
        pieces_at_done = log_n;
        gotv           = rsp_rdata;

        check(seen_fault == f, f ? tg : "R11", 32'(seen_fault), 32'(f));
        check(seen_done == !f, "R9", 32'(seen_done), 32'(!f));
        if (!f) check(rdy_after == 1'b0, "R10", 32'(rdy_after), 32'h0);
        check(pieces_at_done == en, tg, 32'(pieces_at_done), 32'(en));
        for (int i = 0; i < en && i < pieces_at_done; i++) begin
            check(log_addr[i] == ea[i], tg, 32'(log_addr[i]), 32'(ea[i]));
            check(log_strb[i] == es[i], "R5", 32'(log_strb[i]), 32'(es[i]));
        end

        if (!f && v.wr) begin
            for (int k = 0; k < n; k++)
                ref_mem[(v.addr + 8'(k)) & 8'h3F] = 8'(v.data >> (8 * (n - 1 - k)));
            for (int k = 0; k < n; k++) begin
                int a;
                a = (v.addr + k) & 63;
                check(mem[a] == ref_mem[a], "R7", 32'(mem[a]), 32'(ref_mem[a]));
            end
        end else if (!f) begin
            expv = '0;
            for (int k = 0; k < n; k++)
                expv = (expv << 8) | 32'(ref_mem[(v.addr + 8'(k)) & 8'h3F]);
            check(gotv == expv, "R8", gotv, expv);
        end

        @(negedge clk);
        check(rsp_done == 1'b0 && align_fault == 1'b0, "R9", 32'({rsp_done, align_fault}), 32'h0);
        check(req_ready == 1'b1, "R10", 32'(req_ready), 32'h1);
    endtask

    initial begin
        #(4 * 150000);
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        log_n = 0;
        repeat (3) @(negedge clk);
        // R13: idle state straight after reset
        check(req_ready == 1'b1 && bus_valid == 1'b0, "R13", 32'({req_ready, bus_valid}), 32'h2);
        check(rsp_done == 1'b0 && align_fault == 1'b0 && rsp_rdata == 32'h0, "R13",
              rsp_rdata, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6: wait states on an odd longword write and read back
        wait_extra = 2;
        run_vec('{1'b1, 2'd2, 3'd0, 8'h05, 32'h0F1E2D3C});
        run_vec('{1'b0, 2'd2, 3'd0, 8'h05, 32'h0});
        check(rsp_rdata == 32'h0F1E2D3C, "R6", rsp_rdata, 32'h0F1E2D3C);

        // R13: reset in the middle of a split read
        wait_extra = 3;
        @(negedge clk);
        log_n     = 0;
        req_write = 1'b0;
        req_size  = 2'd2;
        req_class = 3'd0;
        req_addr  = AW'(8'h15);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(bus_valid == 1'b1, "R13", 32'(bus_valid), 32'h1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(req_ready == 1'b1 && bus_valid == 1'b0, "R13", 32'({req_ready, bus_valid}), 32'h2);
        check(rsp_done == 1'b0 && align_fault == 1'b0 && rsp_rdata == 32'h0, "R13",
              rsp_rdata, 32'h0);
        wait_extra = 0;
        run_vec('{1'b0, 2'd2, 3'd0, 8'h10, 32'h0});

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule